// File: doc/BRIEF.md
# Address-Filtering Multidrop UART Receiver

This block is the receive half of a serial port meant for a shared multidrop line. Every frame on the line carries a tag that marks it as an address frame or a data frame. When the host sets the filter bit, the receiver throws away every data frame in hardware. Only address frames reach the host. Software reads the address, decides whether this node is the target, and clears the filter bit so that the data frames that follow are accepted. Nodes that are not selected leave the filter set and never see the traffic meant for other nodes.

Two frame formats are supported. The nine-bit format carries the tag in a ninth data bit. The eight-bit format uses the stop bit as the tag, so a data frame there ends with a low stop bit. The line is sampled at sixteen times the bit rate, and each bit is decided by a majority vote around its centre. A `baud_div` input sets the sample rate. A small register interface gives access to the received byte, a status register with the flags, and a control register. A level interrupt signals that a byte is waiting.

Top module: `addr_filter_uart_rx`

## Requirements
- R1: A frame is a low start bit, eight data bits sent LSB first, a ninth bit when the nine-bit mode bit (control register at address 2, bit 2) is set, and a stop bit. One bit period is 16*(baud_div+1) clock cycles. The received byte is read at address 0.
- R2: Each bit is the majority of three samples taken at oversample counts 7, 8 and 9. A start bit whose vote is high is rejected, so a low pulse shorter than half a bit produces no frame.
- R3: While the filter bit is set, a data frame leaves the received byte, receive-complete and framing-error unchanged. In nine-bit mode a data frame has a ninth bit of 0; in eight-bit mode it has a stop bit of 0.
- R4: An address frame (ninth bit 1, or stop bit 1 in eight-bit mode) always loads the received byte and sets receive-complete, whatever the filter bit holds.
- R5: In eight-bit mode with the filter clear, a data frame sets both receive-complete and framing-error.
- R6: The status register at address 1 has receive-complete at bit 7, framing-error at bit 4, overrun at bit 3 and the filter bit at bit 0. All other bits read 0. Framing-error is the inverse of the stop bit of the loaded frame. Receive-complete is set even when framing-error is set.
- R7: A read of address 0 clears receive-complete and overrun.
- R8: The interrupt output is high exactly when the interrupt enable (control bit 7) and receive-complete are both 1. It stays high until the byte is read.
- R9: If an accepted frame completes while receive-complete is still set and no read happens in that cycle, overrun is set. The unread byte and its framing-error flag are kept.
- R10: Only a host write to status bit 0 changes the filter bit. The receiver never changes it. Writes to the other status bits have no effect. All registers reset to zero.
- R11: Control bit 1 returns the ninth bit of the frame that was last loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| baud_div | input | DIV_W | Clock cycles per oversample tick, minus one |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 0 has side effects) |
| reg_addr | input | 2 | Register address: 0 data, 1 status, 2 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational on reg_addr |
| irq | output | 1 | Receive-complete interrupt |

## Verification
The assertions check on every cycle that a filtered data frame leaves the byte and flags untouched, that an accepted frame sets receive-complete, and that overrun keeps the unread byte. They also check that receive-complete only clears through a data read, that the interrupt never fires without receive-complete, and that the filter bit moves only on a host write. Other behaviour can only be shown by the bench's scenarios. These cover the bit order and frame timing on the serial line, the majority vote and rejection of a short glitch, and the eight-bit case where the stop bit is both the tag and the source of a framing error. They also include a side-by-side run of a filtering node and a non-filtering node on the same line, whose flags and bytes must differ.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam int ST_RC   = 7;
  localparam int ST_FE   = 4;
  localparam int ST_OVR  = 3;
  localparam int ST_FILT = 0;

  localparam int CT_IRQEN = 7;
  localparam int CT_NINE  = 2;
  localparam int CT_BIT9  = 1;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;

  function automatic logic majority3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // tag bit of a frame: the ninth bit in nine-bit mode, else the stop bit
  function automatic logic frame_tag(input logic nine, input logic ninth, input logic stop);
    return nine ? ninth : stop;
  endfunction

  function automatic logic frame_keep(input logic filt, input logic tag);
    return !filt || tag;
  endfunction

  function automatic logic [3:0] payload_bits(input logic nine);
    return nine ? 4'd9 : 4'd8;
  endfunction
endpackage

// File: rtl/arx_tick.sv
module arx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else cnt_q <= cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/arx_shift.sv
module arx_shift
  import arx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       nine_mode,
  output logic       frm_valid,
  output logic [7:0] frm_data,
  output logic       frm_ninth,
  output logic       frm_stop
);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2;
  localparam logic [CW-1:0] S_LO  = CW'(MID - 1);
  localparam logic [CW-1:0] S_MID = CW'(MID);
  localparam logic [CW-1:0] S_HI  = CW'(MID + 1);
  localparam logic [CW-1:0] S_END = CW'(OVS - 1);
  localparam logic [CW-1:0] S_ONE = CW'(1);

  rx_state_t   state_q;
  logic [1:0]  sync_q;
  logic        last_q;
  logic [CW-1:0] scnt_q;
  logic [1:0]  win_q;
  logic [3:0]  bidx_q;
  logic [8:0]  shreg_q;
  logic        stop_q;
  logic        done_q;

  logic rxd_s, vote, at_mid, at_end, fall;
  assign rxd_s  = sync_q[1];
  assign vote   = majority3(win_q[1], win_q[0], rxd_s);
  assign at_mid = (scnt_q == S_HI);
  assign at_end = (scnt_q == S_END);
  assign fall   = last_q && !rxd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else sync_q <= {sync_q[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      last_q  <= 1'b1;
      scnt_q  <= '0;
      win_q   <= 2'b11;
      bidx_q  <= '0;
      shreg_q <= '0;
      stop_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick) begin
        last_q <= rxd_s;
        if (state_q == RX_IDLE) begin
          if (fall) begin
            state_q <= RX_START;
            scnt_q  <= S_ONE;
          end
        end else begin
          scnt_q <= scnt_q + S_ONE;
          if (scnt_q == S_LO || scnt_q == S_MID) win_q <= {win_q[0], rxd_s};
          unique case (state_q)
            RX_START: begin
              if (at_mid && vote) state_q <= RX_IDLE;
              else if (at_end) begin
                state_q <= RX_BITS;
                bidx_q  <= '0;
              end
            end
            RX_BITS: begin
              if (at_mid) shreg_q[bidx_q] <= vote;
              if (at_end) begin
                if (bidx_q == payload_bits(nine_mode) - 4'd1) state_q <= RX_STOP;
                else bidx_q <= bidx_q + 4'd1;
              end
            end
            RX_STOP: begin
              if (at_mid) begin
                stop_q  <= vote;
                done_q  <= 1'b1;
                state_q <= RX_IDLE;
              end
            end
            default: state_q <= RX_IDLE;
          endcase
        end
      end
    end
  end

  assign frm_valid = done_q;
  assign frm_data  = shreg_q[7:0];
  assign frm_ninth = nine_mode & shreg_q[8];
  assign frm_stop  = stop_q;
endmodule

// File: rtl/arx_regs.sv
module arx_regs
  import arx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       frm_valid,
  input  logic       frm_is_addr,
  input  logic [7:0] frm_data,
  input  logic       frm_ninth,
  input  logic       frm_stop,
  output logic       nine_mode,
  output logic       frm_accept,
  output logic       data_rd,
  output logic       stat_wr,
  output logic       rc,
  output logic       fe,
  output logic       ovr,
  output logic       filt,
  output logic [7:0] rx_data
);
  logic irq_en_q, nine_q, bit9_q, rc_q, fe_q, ovr_q, filt_q;
  logic [7:0] rxbuf_q;
  logic ctrl_wr, load, overrun_ev;
  logic unused_wbits;

  assign unused_wbits = ^{reg_wdata[6:3], reg_wdata[1]};

  assign data_rd    = reg_rd && reg_addr == ADDR_DATA;
  assign stat_wr    = reg_wr && reg_addr == ADDR_STAT;
  assign ctrl_wr    = reg_wr && reg_addr == ADDR_CTRL;
  assign frm_accept = frm_valid && frame_keep(filt_q, frm_is_addr);
  assign load       = frm_accept && (!rc_q || data_rd);
  assign overrun_ev = frm_accept && rc_q && !data_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= 1'b0;
      nine_q   <= 1'b0;
      bit9_q   <= 1'b0;
      rc_q     <= 1'b0;
      fe_q     <= 1'b0;
      ovr_q    <= 1'b0;
      filt_q   <= 1'b0;
      rxbuf_q  <= '0;
    end else begin
      if (data_rd) begin
        rc_q  <= 1'b0;
        ovr_q <= 1'b0;
      end
      if (load) begin
        rxbuf_q <= frm_data;
        bit9_q  <= frm_ninth;
        fe_q    <= !frm_stop;
        rc_q    <= 1'b1;
      end
      if (overrun_ev) ovr_q <= 1'b1;
      if (stat_wr) filt_q <= reg_wdata[ST_FILT];
      if (ctrl_wr) begin
        irq_en_q <= reg_wdata[CT_IRQEN];
        nine_q   <= reg_wdata[CT_NINE];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_DATA: reg_rdata = rxbuf_q;
      ADDR_STAT: begin
        reg_rdata[ST_RC]   = rc_q;
        reg_rdata[ST_FE]   = fe_q;
        reg_rdata[ST_OVR]  = ovr_q;
        reg_rdata[ST_FILT] = filt_q;
      end
      ADDR_CTRL: begin
        reg_rdata[CT_IRQEN] = irq_en_q;
        reg_rdata[CT_NINE]  = nine_q;
        reg_rdata[CT_BIT9]  = bit9_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign irq       = irq_en_q && rc_q;
  assign nine_mode = nine_q;
  assign rc        = rc_q;
  assign fe        = fe_q;
  assign ovr       = ovr_q;
  assign filt      = filt_q;
  assign rx_data   = rxbuf_q;
endmodule

// File: rtl/addr_filter_uart_rx.sv
module addr_filter_uart_rx
  import arx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq
);
  logic       tick;
  logic       nine_mode;
  logic       frm_valid, frm_ninth, frm_stop, frm_is_addr;
  logic [7:0] frm_data;
  logic       frm_accept, data_rd, stat_wr;
  logic       rc, fe, ovr, filt;
  logic [7:0] rx_data;

  arx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  arx_shift #(.OVS(OVS)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .nine_mode(nine_mode),
    .frm_valid(frm_valid), .frm_data(frm_data), .frm_ninth(frm_ninth),
    .frm_stop(frm_stop)
  );

  assign frm_is_addr = frame_tag(nine_mode, frm_ninth, frm_stop);

  arx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .frm_valid(frm_valid), .frm_is_addr(frm_is_addr),
    .frm_data(frm_data), .frm_ninth(frm_ninth), .frm_stop(frm_stop),
    .nine_mode(nine_mode), .frm_accept(frm_accept), .data_rd(data_rd),
    .stat_wr(stat_wr), .rc(rc), .fe(fe), .ovr(ovr), .filt(filt),
    .rx_data(rx_data)
  );
endmodule

// File: rtl/arx_checker.sv
module arx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frm_valid,
  input logic       frm_accept,
  input logic       frm_is_addr,
  input logic       data_rd,
  input logic       stat_wr,
  input logic       filt,
  input logic       rc,
  input logic       fe,
  input logic       ovr,
  input logic [7:0] rx_data,
  input logic [7:0] frm_data,
  input logic       irq
);
  a_r3_filtered_frame_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && filt && !frm_is_addr && !data_rd |=> $stable(rx_data) && $stable(rc) && $stable(fe));

  a_r4_address_loads: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && frm_is_addr && !rc |=> rc && rx_data == $past(frm_data));

  a_r6_accept_sets_rc: assert property (@(posedge clk) disable iff (!rst_n)
    frm_accept |=> rc);

  a_r7_rc_holds_until_read: assert property (@(posedge clk) disable iff (!rst_n)
    rc && !data_rd |=> rc);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !frm_accept |=> !rc && !ovr);

  a_r8_irq_needs_rc: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rc);

  a_r9_overrun_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
    frm_accept && rc && !data_rd |=> ovr && $stable(rx_data) && $stable(fe));

  a_r10_filter_host_only: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> $stable(filt));
endmodule

bind addr_filter_uart_rx arx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_accept(frm_accept),
  .frm_is_addr(frm_is_addr), .data_rd(data_rd), .stat_wr(stat_wr),
  .filt(filt), .rc(rc), .fe(fe), .ovr(ovr), .rx_data(rx_data),
  .frm_data(frm_data), .irq(irq)
);

// File: tb/addr_filter_uart_rx_test.sv
module addr_filter_uart_rx_test;
  localparam int DIV   = 3;
  localparam int BITCK = 16 * (DIV + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic       wr [2];
  logic       rd [2];
  logic [1:0] addr [2];
  logic [7:0] wdata [2];
  logic [7:0] rdata [2];
  logic       irq_o [2];
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  // index 0: node with the filter set; index 1: node with the filter clear
  addr_filter_uart_rx uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_div(16'(DIV)),
    .reg_wr(wr[0]), .reg_rd(rd[0]), .reg_addr(addr[0]), .reg_wdata(wdata[0]),
    .reg_rdata(rdata[0]), .irq(irq_o[0])
  );
  addr_filter_uart_rx uut_b (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_div(16'(DIV)),
    .reg_wr(wr[1]), .reg_rd(rd[1]), .reg_addr(addr[1]), .reg_wdata(wdata[1]),
    .reg_rdata(rdata[1]), .irq(irq_o[1])
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_read(input int n, input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr[n] = a;
    rd[n] = 1'b1;
    #1 d = rdata[n];
    @(negedge clk);
    rd[n] = 1'b0;
  endtask

  task automatic reg_write(input int n, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr[n] = a;
    wdata[n] = d;
    wr[n] = 1'b1;
    @(negedge clk);
    wr[n] = 1'b0;
  endtask

  task automatic expect_reg(input int n, input logic [1:0] a, input int exp, input string req);
    logic [7:0] d;
    reg_read(n, a, d);
    chk(req, int'(d), exp);
  endtask

  task automatic line_bit(input logic v);
    rxd = v;
    repeat (BITCK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic ninth, input logic stop, input logic nine);
    line_bit(1'b0);
    for (int i = 0; i < 8; i++) line_bit(d[i]);
    if (nine) line_bit(ninth);
    line_bit(stop);
    line_bit(1'b1);
    line_bit(1'b1);
  endtask

  task automatic t_reset;
    for (int n = 0; n < 2; n++) begin
      expect_reg(n, 2'd1, 8'h00, "R10 reset status");
      expect_reg(n, 2'd2, 8'h00, "R10 reset control");
      expect_reg(n, 2'd0, 8'h00, "R10 reset data");
      chk("R8 reset irq", int'(irq_o[n]), 0);
    end
  endtask

  task automatic t_nine_bit;
    reg_write(0, 2'd2, 8'h04);
    reg_write(1, 2'd2, 8'h04);
    reg_write(0, 2'd1, 8'h01);
    send_frame(8'h5A, 1'b1, 1'b1, 1'b1);
    expect_reg(0, 2'd1, 8'h81, "R4 filtered node takes address");
    expect_reg(0, 2'd2, 8'h06, "R11 ninth bit of address");
    expect_reg(0, 2'd0, 8'h5A, "R1 R4 address byte");
    expect_reg(1, 2'd0, 8'h5A, "R1 open node address byte");
    expect_reg(0, 2'd1, 8'h01, "R7 read clears rc");
    expect_reg(1, 2'd1, 8'h00, "R7 read clears rc open node");
    send_frame(8'h33, 1'b0, 1'b1, 1'b1);
    expect_reg(0, 2'd1, 8'h01, "R3 filtered data leaves flags");
    expect_reg(0, 2'd0, 8'h5A, "R3 filtered data leaves byte");
    expect_reg(1, 2'd1, 8'h80, "R3 open node takes data");
    expect_reg(1, 2'd2, 8'h04, "R11 ninth bit of data");
    expect_reg(1, 2'd0, 8'h33, "R1 data byte");
  endtask

  task automatic t_filter_host;
    expect_reg(0, 2'd1, 8'h01, "R10 receiver keeps filter set");
    reg_write(1, 2'd1, 8'hFE);
    expect_reg(1, 2'd1, 8'h00, "R10 read-only status bits ignore writes");
    reg_write(0, 2'd1, 8'h00);
    send_frame(8'h77, 1'b0, 1'b1, 1'b1);
    expect_reg(0, 2'd1, 8'h80, "R10 cleared filter accepts data");
    expect_reg(0, 2'd0, 8'h77, "R10 data byte after unfilter");
    expect_reg(1, 2'd0, 8'h77, "R1 open node byte");
    reg_write(0, 2'd1, 8'h01);
  endtask

  task automatic t_irq;
    reg_write(1, 2'd2, 8'h84);
    send_frame(8'h11, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    chk("R8 irq with enable and rc", int'(irq_o[1]), 1);
    chk("R8 no irq without enable", int'(irq_o[0]), 0);
    expect_reg(0, 2'd1, 8'h81, "R8 rc set without irq");
    repeat (20) @(negedge clk);
    chk("R8 irq held until read", int'(irq_o[1]), 1);
    expect_reg(1, 2'd0, 8'h11, "R7 byte read");
    chk("R7 irq dropped by read", int'(irq_o[1]), 0);
    expect_reg(0, 2'd0, 8'h11, "R4 filtered node address");
  endtask

  task automatic t_eight_bit;
    reg_write(0, 2'd2, 8'h00);
    reg_write(1, 2'd2, 8'h00);
    send_frame(8'hA5, 1'b0, 1'b0, 1'b0);
    expect_reg(0, 2'd1, 8'h01, "R3 eight-bit data filtered");
    expect_reg(0, 2'd0, 8'h11, "R3 eight-bit byte untouched");
    expect_reg(1, 2'd1, 8'h90, "R5 R6 rc and fe on data frame");
    expect_reg(1, 2'd0, 8'hA5, "R5 eight-bit data byte");
    send_frame(8'hC3, 1'b0, 1'b1, 1'b0);
    expect_reg(0, 2'd1, 8'h81, "R4 eight-bit address accepted");
    expect_reg(1, 2'd1, 8'h80, "R6 fe follows good stop");
    expect_reg(0, 2'd0, 8'hC3, "R4 eight-bit address byte");
    expect_reg(1, 2'd0, 8'hC3, "R1 eight-bit address byte");
  endtask

  task automatic t_overrun;
    send_frame(8'h01, 1'b0, 1'b1, 1'b0);
    send_frame(8'h02, 1'b0, 1'b1, 1'b0);
    expect_reg(1, 2'd1, 8'h88, "R9 overrun flag");
    expect_reg(1, 2'd0, 8'h01, "R9 unread byte kept");
    expect_reg(1, 2'd1, 8'h00, "R7 read clears overrun");
    expect_reg(0, 2'd1, 8'h89, "R9 overrun on filtered node");
    expect_reg(0, 2'd0, 8'h01, "R9 filtered node keeps byte");
  endtask

  task automatic t_glitch;
    rxd = 1'b0;
    repeat (3 * (DIV + 1)) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BITCK) @(negedge clk);
    expect_reg(0, 2'd1, 8'h01, "R2 glitch rejected filtered node");
    expect_reg(1, 2'd1, 8'h00, "R2 glitch rejected open node");
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    for (int n = 0; n < 2; n++) begin
      wr[n] = 1'b0;
      rd[n] = 1'b0;
      addr[n] = 2'd0;
      wdata[n] = 8'h00;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_nine_bit();
    t_filter_host();
    t_irq();
    t_eight_bit();
    t_overrun();
    t_glitch();
    report();
  end
endmodule